// File: doc/BRIEF.md
# Card Presence Debouncer

This block watches the card-detect input of a smart card interface and turns its noisy level into clean presence events. The raw pin first crosses into the module clock domain through a two-stage synchronizer. The synchronized level is then interpreted through a polarity select and debounced. Insertion and removal use different sampling periods, so a card must stay seated for longer before it is accepted than it must stay absent before it is dropped.

Each confirmed event sets a sticky flag that software clears by writing one to it. The two flags are ORed into a single interrupt. When automatic deactivation is enabled, a confirmed removal also sends a one-cycle request to the deactivation sequencer, which lies outside this block. Detection runs only while the controller enable is high. After reset, and while the enable is low, the debounced state is "no card".

Top module: `card_detect`

## Requirements
- R1: `pinStatus` is the raw `cdPin` level delayed through two flip-flops. It follows the pin at the second rising clock edge after a change, whether or not the block is enabled.
- R2: With `cdPolarity` = 0, a low pin level means a card is present. A high-to-low change therefore leads to an insertion, and a low-to-high change leads to a removal.
- R3: With `cdPolarity` = 1, a high pin level means a card is present. A low-to-high change therefore leads to an insertion.
- R4: An insertion is accepted only after two consecutive samples, taken every 384 clocks, both see the card present. The flag therefore never rises sooner than 384 clocks after the pin change and always rises within 780 clocks of it.
- R5: A removal is accepted only after two consecutive samples, taken every 128 clocks, both see the card absent. The flag therefore never rises sooner than 128 clocks after the pin change and always rises within 270 clocks of it.
- R6: A presence pulse on the pin that is shorter than one insertion sampling period sets no flag.
- R7: `insertFlag` is sticky. It stays set until a one-cycle pulse on `clrInsert` clears it.
- R8: `removeFlag` is sticky. It stays set until a one-cycle pulse on `clrRemove` clears it.
- R9: `cardIrq` is high while either event flag is set. It falls only after both flags have been cleared.
- R10: While `ctrlEn` is low, no event flag rises and the debounced state returns to "no card". A card that is already present when the enable goes high produces exactly one insertion.
- R11: With `autoDeactEn` = 1, each accepted removal produces exactly one single-cycle pulse on `deactReq`, in the same cycle that `removeFlag` rises. With `autoDeactEn` = 0, a removal produces no pulse.
- R12: Out of reset, `insertFlag`, `removeFlag`, `cardIrq` and `deactReq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cdPin | input | 1 | Raw card-detect pin, asynchronous |
| cdPolarity | input | 1 | 0: low level means present; 1: high level means present |
| ctrlEn | input | 1 | Controller enable; detection runs only while high |
| clrInsert | input | 1 | Write-one-to-clear strobe for the insert flag |
| clrRemove | input | 1 | Write-one-to-clear strobe for the remove flag |
| autoDeactEn | input | 1 | Request deactivation automatically on removal |
| pinStatus | output | 1 | Synchronized live pin level |
| insertFlag | output | 1 | Sticky insertion event |
| removeFlag | output | 1 | Sticky removal event |
| cardIrq | output | 1 | OR of the two event flags |
| deactReq | output | 1 | One-cycle deactivation request |

## Verification
The pin is driven with four kinds of pattern:
- Clean, long-held insertions and removals. Each is checked once just before its earliest allowed acceptance and once just after its latest, so both the sampling period and the two-sample rule are tested from both sides.
- A presence glitch shorter than one sampling period. This separates real debouncing from simple edge capture.
- The same pin levels under both polarity settings. This shows that the active level follows the select.
- A card held present while the enable is low, and then enabled. This shows that a disabled block stays silent and that a card already present yields exactly one insertion.

// File: rtl/card_detect_pkg.sv
package card_detect_pkg;
  // Strobes from the debounce control to the datapath
  typedef struct packed {
    logic evInsert;
    logic evRemove;
  } cdEvents_t;
endpackage

// File: rtl/cd_datapath.sv
module cd_datapath
  import card_detect_pkg::*;
#(
  parameter int BASE_DIV    = 128,
  parameter int INS_MULT    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cdPin,
  input  logic      cdPolarity,
  input  logic      ctrlEn,
  input  logic      clrInsert,
  input  logic      clrRemove,
  input  logic      autoDeactEn,
  input  cdEvents_t ev,
  output logic      tickFast,
  output logic      tickSlow,
  output logic      cardSeen,
  output logic      pinStatus,
  output logic      insertFlag,
  output logic      removeFlag,
  output logic      cardIrq,
  output logic      deactReq
);
  localparam int CW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int MW = (INS_MULT > 1) ? $clog2(INS_MULT) : 1;
  localparam logic [CW-1:0] BASE_LAST = CW'(BASE_DIV - 1);
  localparam logic [MW-1:0] MULT_LAST = MW'(INS_MULT - 1);

  // Synchronizer chain, one flop per stage
  logic [SYNC_STAGES-1:0] syncChain;
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : gSync
      if (gi == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= cdPin;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= syncChain[gi-1];
      end
    end
  endgenerate

  assign pinStatus = syncChain[SYNC_STAGES-1];
  assign cardSeen  = cdPolarity ? pinStatus : ~pinStatus;

  // Sampling prescaler: fast tick every BASE_DIV clocks, slow every INS_MULT fast ticks
  logic [CW-1:0] baseCnt;
  logic [MW-1:0] multCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCnt <= '0;
      multCnt <= '0;
    end else if (!ctrlEn) begin
      baseCnt <= '0;
      multCnt <= '0;
    end else if (baseCnt == BASE_LAST) begin
      baseCnt <= '0;
      multCnt <= (multCnt == MULT_LAST) ? '0 : multCnt + 1'b1;
    end else begin
      baseCnt <= baseCnt + 1'b1;
    end
  end

  assign tickFast = ctrlEn && (baseCnt == BASE_LAST);
  assign tickSlow = tickFast && (multCnt == MULT_LAST);

  // Sticky event flags; a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      insertFlag <= 1'b0;
      removeFlag <= 1'b0;
      deactReq   <= 1'b0;
    end else begin
      insertFlag <= ev.evInsert | (insertFlag & ~clrInsert);
      removeFlag <= ev.evRemove | (removeFlag & ~clrRemove);
      deactReq   <= ev.evRemove & autoDeactEn;
    end
  end

  assign cardIrq = insertFlag | removeFlag;
endmodule

// File: rtl/cd_debounce_ctl.sv
module cd_debounce_ctl
  import card_detect_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctrlEn,
  input  logic      tickFast,
  input  logic      tickSlow,
  input  logic      cardSeen,
  output cdEvents_t ev
);
  logic cardIn;   // debounced presence
  logic pend;     // one disagreeing sample already seen
  logic sampleNow;
  logic accept;

  // An absent card is sampled on the slow tick, a present card on the fast tick
  assign sampleNow = cardIn ? tickFast : tickSlow;
  assign accept    = sampleNow && (cardSeen != cardIn) && pend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cardIn <= 1'b0;
      pend   <= 1'b0;
    end else if (!ctrlEn) begin
      cardIn <= 1'b0;
      pend   <= 1'b0;
    end else if (sampleNow) begin
      if (cardSeen != cardIn) begin
        if (pend) begin
          cardIn <= cardSeen;
          pend   <= 1'b0;
        end else begin
          pend <= 1'b1;
        end
      end else begin
        pend <= 1'b0;
      end
    end
  end

  always_comb begin
    ev.evInsert = accept & ~cardIn;
    ev.evRemove = accept &  cardIn;
  end
endmodule

// File: rtl/card_detect.sv
module card_detect
  import card_detect_pkg::*;
#(
  parameter int BASE_DIV    = 128,
  parameter int INS_MULT    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cdPin,
  input  logic cdPolarity,
  input  logic ctrlEn,
  input  logic clrInsert,
  input  logic clrRemove,
  input  logic autoDeactEn,
  output logic pinStatus,
  output logic insertFlag,
  output logic removeFlag,
  output logic cardIrq,
  output logic deactReq
);
  cdEvents_t ev;
  logic tickFast, tickSlow, cardSeen;

  cd_datapath #(
    .BASE_DIV(BASE_DIV), .INS_MULT(INS_MULT), .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk(clk), .rstN(rstN), .cdPin(cdPin), .cdPolarity(cdPolarity),
    .ctrlEn(ctrlEn), .clrInsert(clrInsert), .clrRemove(clrRemove),
    .autoDeactEn(autoDeactEn), .ev(ev), .tickFast(tickFast),
    .tickSlow(tickSlow), .cardSeen(cardSeen), .pinStatus(pinStatus),
    .insertFlag(insertFlag), .removeFlag(removeFlag), .cardIrq(cardIrq),
    .deactReq(deactReq)
  );

  cd_debounce_ctl uCtl (
    .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .tickFast(tickFast),
    .tickSlow(tickSlow), .cardSeen(cardSeen), .ev(ev)
  );
endmodule

// File: rtl/card_detect_checker.sv
module card_detect_checker (
  input logic clk,
  input logic rstN,
  input logic ctrlEn,
  input logic clrInsert,
  input logic clrRemove,
  input logic autoDeactEn,
  input logic insertFlag,
  input logic removeFlag,
  input logic cardIrq,
  input logic deactReq
);
  AST_INS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(insertFlag) |-> $past(ctrlEn));  // R10
  AST_REM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(removeFlag) |-> $past(ctrlEn));  // R10
  AST_INS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(insertFlag) && !$past(clrInsert)) |-> insertFlag);  // R7
  AST_REM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(removeFlag) && !$past(clrRemove)) |-> removeFlag);  // R8
  AST_IRQ_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cardIrq) |-> ($past(clrInsert) || $past(clrRemove)));  // R9
  AST_DEACT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    deactReq |=> !deactReq);  // R11
  AST_DEACT_WITH_REMOVE: assert property (@(posedge clk) disable iff (!rstN)
    deactReq |-> ($rose(removeFlag) || removeFlag) && $past(autoDeactEn));  // R11
endmodule

bind card_detect card_detect_checker uChk (
  .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .clrInsert(clrInsert),
  .clrRemove(clrRemove), .autoDeactEn(autoDeactEn), .insertFlag(insertFlag),
  .removeFlag(removeFlag), .cardIrq(cardIrq), .deactReq(deactReq)
);

// File: tb/tb_card_detect.sv
module tb_card_detect;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cdPin = 1'b1, cdPolarity = 1'b0, ctrlEn = 1'b0;
  logic clrInsert = 1'b0, clrRemove = 1'b0, autoDeactEn = 1'b1;
  logic pinStatus, insertFlag, removeFlag, cardIrq, deactReq;

  int checks = 0;
  int fails = 0;
  int deactCnt = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  card_detect dut (
    .clk(clk), .rstN(rstN), .cdPin(cdPin), .cdPolarity(cdPolarity),
    .ctrlEn(ctrlEn), .clrInsert(clrInsert), .clrRemove(clrRemove),
    .autoDeactEn(autoDeactEn), .pinStatus(pinStatus), .insertFlag(insertFlag),
    .removeFlag(removeFlag), .cardIrq(cardIrq), .deactReq(deactReq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rstN && deactReq) deactCnt <= deactCnt + 1;
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic checkInt(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // pin, clrIns, clrRem, wait, expIns, expRem, expStatus  (polarity 0: low = present)
  typedef struct packed {
    logic pin; logic cI; logic cR; int unsigned w;
    logic eIns; logic eRem; logic eSt;
  } step_t;
  localparam int NSTEP = 9;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b1, 1'b0, 1'b0, 1000, 1'b0, 1'b0, 1'b1},  // idle, no card        R2
    '{1'b0, 1'b0, 1'b0,  370, 1'b0, 1'b0, 1'b0},  // too early to insert  R4
    '{1'b0, 1'b0, 1'b0,  420, 1'b1, 1'b0, 1'b0},  // insert accepted      R4 R2
    '{1'b0, 1'b1, 1'b0,   10, 1'b0, 1'b0, 1'b0},  // clear insert         R7
    '{1'b1, 1'b0, 1'b0,  120, 1'b0, 1'b0, 1'b1},  // too early to remove  R5
    '{1'b1, 1'b0, 1'b0,  150, 1'b0, 1'b1, 1'b1},  // removal accepted     R5 R2
    '{1'b1, 1'b0, 1'b1,   10, 1'b0, 1'b0, 1'b1},  // clear remove         R8
    '{1'b0, 1'b0, 1'b0,   50, 1'b0, 1'b0, 1'b0},  // short presence pulse R6
    '{1'b1, 1'b0, 1'b0, 1000, 1'b0, 1'b0, 1'b1}   // glitch rejected      R6
  };

  initial begin : watchdog
    wait (cycles > 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    waitCyc(5);
    // R12: reset state
    check("R12 insertFlag", insertFlag, 1'b0);
    check("R12 removeFlag", removeFlag, 1'b0);
    check("R12 cardIrq", cardIrq, 1'b0);
    check("R12 deactReq", deactReq, 1'b0);
    rstN = 1'b1;
    waitCyc(2);
    ctrlEn = 1'b1;

    for (int i = 0; i < NSTEP; i++) begin
      cdPin = STEPS[i].pin;
      clrInsert = STEPS[i].cI;
      clrRemove = STEPS[i].cR;
      waitCyc(1);
      clrInsert = 1'b0;
      clrRemove = 1'b0;
      waitCyc(int'(STEPS[i].w) - 1);
      check($sformatf("R4/R5/R6/R7/R8 step %0d insertFlag", i), insertFlag, STEPS[i].eIns);
      check($sformatf("R4/R5/R6/R7/R8 step %0d removeFlag", i), removeFlag, STEPS[i].eRem);
      check($sformatf("R1 step %0d pinStatus", i), pinStatus, STEPS[i].eSt);
    end
    checkInt("R11 one deactivation pulse", deactCnt, 1);

    // R3: polarity 1, high = present
    ctrlEn = 1'b0; cdPolarity = 1'b1; cdPin = 1'b0;
    waitCyc(5);
    ctrlEn = 1'b1;
    waitCyc(1000);
    check("R3 low is absent", insertFlag, 1'b0);
    cdPin = 1'b1;
    waitCyc(800);
    check("R3 high inserts", insertFlag, 1'b1);
    check("R9 irq with insert", cardIrq, 1'b1);

    // R11: no request with auto deactivation off
    autoDeactEn = 1'b0;
    cdPin = 1'b0;
    waitCyc(300);
    check("R5 removal pol1", removeFlag, 1'b1);
    checkInt("R11 no pulse when disabled", deactCnt, 1);

    // R9: irq falls only after both clears
    clrInsert = 1'b1; waitCyc(1); clrInsert = 1'b0; waitCyc(1);
    check("R7 insert cleared", insertFlag, 1'b0);
    check("R9 irq held by remove", cardIrq, 1'b1);
    clrRemove = 1'b1; waitCyc(1); clrRemove = 1'b0; waitCyc(1);
    check("R9 irq low after both", cardIrq, 1'b0);

    // R10: disabled block ignores a present card, then reports it once on enable
    ctrlEn = 1'b0;
    cdPin = 1'b1;
    waitCyc(1000);
    check("R10 no event while disabled", insertFlag, 1'b0);
    ctrlEn = 1'b1;
    waitCyc(800);
    check("R10 insert on enable", insertFlag, 1'b1);
    check("R10 no spurious remove", removeFlag, 1'b0);

    // R1: two-flop synchronizer latency, with the block disabled
    ctrlEn = 1'b0;
    waitCyc(3);
    cdPin = 1'b0;
    waitCyc(1);
    check("R1 status after one edge", pinStatus, 1'b1);
    waitCyc(1);
    check("R1 status after two edges", pinStatus, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule